// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is a parameterised register (eight bits by default) that, on each rising clock edge, either keeps its value, shifts one place toward the high end, shifts one place toward the low end, or loads a new word. A two-bit mode input picks the action. One bidirectional tri-state bus serves both purposes: it presents the register contents when the block drives it, and it carries the word to be loaded when the block lets go of it.

Two active-low enables control the bus drivers. Two serial outputs always show the lowest and highest register bits, and are never released. Two serial inputs feed the empty end of the register during a shift. Together these let several registers be chained into a longer one. An active-low clear empties the register at once, whether or not the clock is running.

Top module: `ushift_bidir`

## Requirements
- R1: While clr_n is low, every register bit is 0. This takes effect without waiting for a clock edge, and the bit is visible on ser_out_lo, on ser_out_hi and on the driven bus.
- R2: With mode = 2'b00 (hold), the register keeps its value across a rising clock edge.
- R3: With mode = 2'b01 (shift up), each bit i moves to bit i+1 on the rising edge, and ser_in_lo enters bit 0.
- R4: With mode = 2'b10 (shift down), each bit i moves to bit i-1 on the rising edge, and ser_in_hi enters the top bit (bit WIDTH-1).
- R5: With mode = 2'b11 (load), the register takes the value on pio at the rising edge.
- R6: When oe_a_n and oe_b_n are both low and mode is not 2'b11, the block drives the register contents onto pio.
- R7: When either oe_a_n or oe_b_n is high, the block releases pio to high impedance, so a value placed on the bus from outside is read back unchanged.
- R8: With mode = 2'b11, the block releases pio even when both enables are low.
- R9: ser_out_lo always equals register bit 0 and ser_out_hi always equals bit WIDTH-1. This holds during clear and while pio is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_in_lo | input | 1 | Serial data that enters bit 0 during shift up |
| ser_in_hi | input | 1 | Serial data that enters the top bit during shift down |
| oe_a_n | input | 1 | Bus output enable A, active low |
| oe_b_n | input | 1 | Bus output enable B, active low |
| pio | inout | WIDTH | Shared bus: register contents out, load data in |
| ser_out_lo | output | 1 | Register bit 0 |
| ser_out_hi | output | 1 | Register bit WIDTH-1 |

## Verification
The bench builds the block with the default WIDTH of 8. At this width, a random run of a few hundred cycles covers every mode together with every combination of the two enables. It also often walks a marked bit all the way to each end, where it leaves through the serial outputs while a serial input fills the empty slot. Directed steps cover a clear in the middle of a cycle and a load with both enables low. In both cases the bus must be released so that the bench's value is captured.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_next_state.sv
module usr_next_state
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  usr_mode_e        mode_e,
  input  logic [WIDTH-1:0] cur,
  input  logic             ser_in_lo,
  input  logic             ser_in_hi,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] nxt
);
  localparam int TOP = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_below;
    logic from_above;
    if (i == 0) begin : g_lo_end
      assign from_below = ser_in_lo;
    end else begin : g_lo_mid
      assign from_below = cur[i-1];
    end
    if (i == TOP) begin : g_hi_end
      assign from_above = ser_in_hi;
    end else begin : g_hi_mid
      assign from_above = cur[i+1];
    end

    always_comb begin
      unique case (mode_e)
        MODE_HOLD: nxt[i] = cur[i];
        MODE_UP:   nxt[i] = from_below;
        MODE_DOWN: nxt[i] = from_above;
        default:   nxt[i] = bus_in[i];
      endcase
    end
  end
endmodule

// File: rtl/usr_bus_ctrl.sv
module usr_bus_ctrl
  import usr_pkg::*;
(
  input  usr_mode_e mode_e,
  input  logic      oe_a_n,
  input  logic      oe_b_n,
  output logic      drive_en
);
  logic enables_on;
  assign enables_on = ~(oe_a_n | oe_b_n);
  assign drive_en   = enables_on & (mode_e != MODE_LOAD);
endmodule

// File: rtl/ushift_bidir.sv
module ushift_bidir
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [1:0]       mode,
  input  logic             ser_in_lo,
  input  logic             ser_in_hi,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  inout  wire  [WIDTH-1:0] pio,
  output logic             ser_out_lo,
  output logic             ser_out_hi
);
  localparam int TOP = WIDTH - 1;

  usr_mode_e        mode_e;
  logic [WIDTH-1:0] store_q;
  logic [WIDTH-1:0] store_d;
  logic             drive_en;

  assign mode_e = usr_mode_e'(mode);

  usr_next_state #(.WIDTH(WIDTH)) u_next (
    .mode_e    (mode_e),
    .cur       (store_q),
    .ser_in_lo (ser_in_lo),
    .ser_in_hi (ser_in_hi),
    .bus_in    (pio),
    .nxt       (store_d)
  );

  usr_bus_ctrl u_bus (
    .mode_e   (mode_e),
    .oe_a_n   (oe_a_n),
    .oe_b_n   (oe_b_n),
    .drive_en (drive_en)
  );

  // Storage flops: asynchronous clear, all changes on the rising edge.
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) store_q <= '0;
    else        store_q <= store_d;
  end

  assign pio        = drive_en ? store_q : {WIDTH{1'bz}};
  assign ser_out_lo = store_q[0];
  assign ser_out_hi = store_q[TOP];

  // R2
  a_r2_hold_keeps: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b00) |=> (store_q == $past(store_q)));
  // R3
  a_r3_shift_up: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b01) |=> (store_q == {$past(store_q[TOP-1:0]), $past(ser_in_lo)}));
  // R4
  a_r4_shift_down: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b10) |=> (store_q == {$past(ser_in_hi), $past(store_q[TOP:1])}));
  // R5
  a_r5_load_bus: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b11) |=> (store_q == $past(pio)));
  // R6
  a_r6_bus_shows_store: assert property (@(posedge clk) disable iff (!clr_n)
    (!oe_a_n && !oe_b_n && mode != 2'b11) |-> (pio == store_q));
endmodule

// File: tb/ushift_bidir_tb_top.sv
module ushift_bidir_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clr_n = 1'b1;
  logic [1:0]   mode = 2'b00;
  logic         ser_in_lo = 1'b0;
  logic         ser_in_hi = 1'b0;
  logic         oe_a_n = 1'b1;
  logic         oe_b_n = 1'b1;
  logic         tb_drive = 1'b0;
  logic [W-1:0] tb_data = '0;
  wire  [W-1:0] pio;
  logic         ser_out_lo;
  logic         ser_out_hi;

  int checks = 0;
  int failures = 0;
  int model = 0;

  assign pio = tb_drive ? tb_data : {W{1'bz}};

  always #5 clk = ~clk;

  ushift_bidir #(.WIDTH(W)) dut_i (
    .clk(clk), .clr_n(clr_n), .mode(mode),
    .ser_in_lo(ser_in_lo), .ser_in_hi(ser_in_hi),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .pio(pio),
    .ser_out_lo(ser_out_lo), .ser_out_hi(ser_out_hi)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit bus_driven(input logic [1:0] m, input logic a, input logic b);
    return (a == 1'b0) && (b == 1'b0) && (m != 2'b11);
  endfunction

  // Observe all outputs against the model (R6, R7, R8, R9).
  task automatic observe();
    check("R9 ser_out_lo", int'(ser_out_lo), model & 1);
    check("R9 ser_out_hi", int'(ser_out_hi), (model >> (W-1)) & 1);
    if (bus_driven(mode, oe_a_n, oe_b_n))
      check("R6 bus drive", int'(pio), model);
    else if (mode == 2'b11)
      check("R8 load releases bus", int'(pio), int'(tb_data));
    else
      check("R7 bus released", int'(pio), int'(tb_data));
  endtask

  // Apply inputs at the falling edge, advance one rising edge, check at the next falling edge.
  task automatic step(input logic [1:0] m, input logic sl, input logic sh,
                      input logic a, input logic b, input logic [W-1:0] d);
    mode = m; ser_in_lo = sl; ser_in_hi = sh; oe_a_n = a; oe_b_n = b;
    tb_data = d;
    tb_drive = !bus_driven(m, a, b);
    #1;
    observe();
    @(posedge clk);
    case (m)
      2'b00: model = model;                                   // R2
      2'b01: model = ((model << 1) | int'(sl)) % (1 << W);    // R3
      2'b10: model = (model >> 1) + (int'(sh) << (W-1));      // R4
      default: model = int'(d);                               // R5
    endcase
    @(negedge clk);
    check(m == 2'b00 ? "R2 hold" : m == 2'b01 ? "R3 shift up" :
          m == 2'b10 ? "R4 shift down" : "R5 load", int'(ser_out_lo), model & 1);
    check("R9 top bit after edge", int'(ser_out_hi), (model >> (W-1)) & 1);
    observe();
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2 clr_n = 1'b0;
    #1;
    model = 0;
    oe_a_n = 1'b0; oe_b_n = 1'b0; tb_drive = 1'b0;
    #1;
    check("R1 clear bus", int'(pio), 0);
    check("R1 clear ser lo", int'(ser_out_lo), 0);
    check("R1 clear ser hi", int'(ser_out_hi), 0);
    @(negedge clk);
    @(negedge clk);
    clr_n = 1'b1;
    @(negedge clk);

    // Directed: load with both enables low (R8, R5).
    step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5);
    step(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R5 loaded word on bus", int'(pio), 'hA5);
    // Walk a bit up and out the top (R3, R9).
    step(2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01);
    for (int k = 0; k < W; k++) step(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R3 bit shifted out", model, 0);
    // Fill from the top (R4).
    for (int k = 0; k < W; k++) step(2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 8'h3C);
    check("R4 filled from top", model, 'hFF);
    // Hold with bus released by B then by A (R2, R7).
    step(2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h5A);
    step(2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 8'hC3);

    // Random run.
    for (int k = 0; k < 400; k++)
      step(2'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom % 3 == 0), 1'($urandom % 3 == 0), 8'($urandom));

    // Clear in mid-cycle with bus released (R1, R9).
    step(2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF);
    #2 clr_n = 1'b0; model = 0;
    #1;
    check("R1 mid-cycle clear ser lo", int'(ser_out_lo), 0);
    check("R1 mid-cycle clear ser hi", int'(ser_out_hi), 0);
    @(posedge clk);
    #1;
    check("R1 clear held at edge", int'(ser_out_lo), 0);
    @(negedge clk);
    clr_n = 1'b1;
    step(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule